// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This core runs a program made of 12-bit syllables, four to a 48-bit word. A word is fetched once. Its four syllables then execute one per cycle, starting with the most significant. No syllable names a register. Every operand comes from an operand stack of 32 entries held inside the core, and every result goes back onto that stack. Syllables that refer to memory name a 10-bit index into an external reference table. The table returns either a constant or a 15-bit address. Program memory sits behind a word-fetch port and data memory behind a simple read/write port. Both ports, and the reference table, answer combinationally in the cycle the request is shown.

A syllable's top two bits give its kind:
- `00` pushes its 10-bit field as a literal.
- `01` pushes a reference-table entry.
- `11` pushes the low 15 bits of a reference-table entry, which is an address.
- `10` is an operation. Its low 6 bits choose arithmetic, bitwise logic, comparison, stack shuffling, memory access or a relative jump.

A push onto a full stack or a pop from an empty stack raises a sticky error. The error stops the core until reset.

Top module: `stack_core`

## Requirements
- R1: After reset the core fetches word 0. It executes each fetched word's syllables in the order bits 47:36, 35:24, 23:12, 11:0, one per cycle, and requests the next sequential word only after the fourth syllable.
- R2: A syllable with kind `00` pushes its 10-bit field, zero-extended to 48 bits.
- R3: Kind `01` pushes the reference-table entry selected by the 10-bit field. Kind `11` pushes bits 14:0 of that entry, zero-extended. The index appears on `ref_idx`.
- R4: Operation code 0x01 (add) and 0x02 (subtract) pop the top two entries and push second+top or second−top, in 48-bit two's complement. Bits 9:6 of an operation syllable are ignored.
- R5: Codes 0x03 AND, 0x04 OR and 0x05 equivalence (a 1 wherever the bits match) pop two entries and push the 48-bit result. Code 0x06 replaces the top entry with its bitwise inverse.
- R6: Codes 0x08 =, 0x09 ≠, 0x0A <, 0x0B ≤, 0x0C >, 0x0D ≥ compare second against top as signed numbers. They pop both entries and push 1 for true or 0 for false.
- R7: Code 0x10 swaps the top two entries, 0x11 pushes a copy of the top entry, and 0x12 discards the top entry.
- R8: Code 0x18 writes the second entry to data address top[14:0] and pops both. Code 0x19 does the same write but pops only the address. Code 0x1A replaces the top entry with the data word read at top[14:0].
- R9: Codes 0x20 (forward) and 0x21 (backward) pop an offset and continue at syllable 0 of the word whose address is the current word address plus or minus the offset's low 10 bits.
- R10: Codes 0x22 (forward) and 0x23 (backward) pop an offset (top) and a condition (second). They jump as in R9 only when the condition is nonzero. Both entries are removed whether or not the jump is taken.
- R11: A syllable that would pop more entries than the stack holds, or leave more than 32, does not execute. It sets `stk_err`. After that the core makes no fetch and no data write until reset.
- R12: During reset `stk_err` and `dmem_we` are 0, and a fetch of word 0 is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifetch_req | output | 1 | Instruction word requested |
| ifetch_addr | output | 15 | Word address of requested instruction word |
| ifetch_valid | input | 1 | Instruction word present this cycle |
| ifetch_word | input | 48 | Four packed syllables |
| ref_idx | output | 10 | Reference-table index of current syllable |
| ref_data | input | 48 | Reference-table entry at `ref_idx` |
| dmem_we | output | 1 | Data write strobe |
| dmem_addr | output | 15 | Data address (taken from the top entry) |
| dmem_wdata | output | 48 | Data to write (the second entry) |
| dmem_rdata | input | 48 | Data word read at `dmem_addr` |
| stk_err | output | 1 | Sticky stack underflow/overflow flag |

## Verification
Every program leaves its results in data memory, where the bench reads them.

The arithmetic and comparison programs feed operand pairs in both orders and include negative values. This separates second-versus-top ordering from the reverse, and separates signed comparison from unsigned. Identical operands exercise the equality-boundary outcomes.

The jump programs place sentinel stores on the skipped path. They also end with a pop that must underflow, which shows that the offset and the condition were both removed. Stacks filled to exactly 32 entries and then to 33 separate the legal limit from overflow, and counting fetches shows where the core halted.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;

   typedef enum logic [1:0] {
      SYL_LIT  = 2'b00,
      SYL_REF  = 2'b01,
      SYL_OP   = 2'b10,
      SYL_ADDR = 2'b11
   } syl_kind_e;

   localparam logic [5:0] OP_NOP  = 6'h00;
   localparam logic [5:0] OP_ADD  = 6'h01;
   localparam logic [5:0] OP_SUB  = 6'h02;
   localparam logic [5:0] OP_AND  = 6'h03;
   localparam logic [5:0] OP_OR   = 6'h04;
   localparam logic [5:0] OP_EQV  = 6'h05;
   localparam logic [5:0] OP_NOT  = 6'h06;
   localparam logic [5:0] OP_EQ   = 6'h08;
   localparam logic [5:0] OP_NE   = 6'h09;
   localparam logic [5:0] OP_LT   = 6'h0A;
   localparam logic [5:0] OP_LE   = 6'h0B;
   localparam logic [5:0] OP_GT   = 6'h0C;
   localparam logic [5:0] OP_GE   = 6'h0D;
   localparam logic [5:0] OP_XCH  = 6'h10;
   localparam logic [5:0] OP_DUP  = 6'h11;
   localparam logic [5:0] OP_DEL  = 6'h12;
   localparam logic [5:0] OP_ST   = 6'h18;
   localparam logic [5:0] OP_STK  = 6'h19;
   localparam logic [5:0] OP_LD   = 6'h1A;
   localparam logic [5:0] OP_JF   = 6'h20;
   localparam logic [5:0] OP_JB   = 6'h21;
   localparam logic [5:0] OP_JCF  = 6'h22;
   localparam logic [5:0] OP_JCB  = 6'h23;

   typedef enum logic [3:0] {
      X_NOP, X_PUSH, X_BIN, X_UN, X_XCH, X_DUP, X_DEL,
      X_ST, X_STK, X_LD, X_JMP, X_JC
   } exec_e;

   typedef struct packed {
      exec_e      act;
      logic [1:0] pops;
      logic [1:0] pushes;
      logic       back;
   } dec_s;

endpackage

// File: rtl/stack_core_dec.sv
module stack_core_dec
   import stack_core_pkg::*;
(
   input  logic [1:0] kind,
   input  logic [5:0] op,
   output dec_s       dec
);

   always_comb begin
      dec = '{act: X_NOP, pops: 2'd0, pushes: 2'd0, back: 1'b0};
      if (syl_kind_e'(kind) != SYL_OP) begin
         dec.act    = X_PUSH;
         dec.pushes = 2'd1;
      end else begin
         unique case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_EQV,
            OP_EQ, OP_NE, OP_LT, OP_LE, OP_GT, OP_GE: begin
               dec.act = X_BIN; dec.pops = 2'd2; dec.pushes = 2'd1;
            end
            OP_NOT: begin dec.act = X_UN;  dec.pops = 2'd1; dec.pushes = 2'd1; end
            OP_XCH: begin dec.act = X_XCH; dec.pops = 2'd2; dec.pushes = 2'd2; end
            OP_DUP: begin dec.act = X_DUP; dec.pops = 2'd1; dec.pushes = 2'd2; end
            OP_DEL: begin dec.act = X_DEL; dec.pops = 2'd1; end
            OP_ST:  begin dec.act = X_ST;  dec.pops = 2'd2; end
            OP_STK: begin dec.act = X_STK; dec.pops = 2'd2; dec.pushes = 2'd1; end
            OP_LD:  begin dec.act = X_LD;  dec.pops = 2'd1; dec.pushes = 2'd1; end
            OP_JF, OP_JB: begin
               dec.act = X_JMP; dec.pops = 2'd1; dec.back = (op == OP_JB);
            end
            OP_JCF, OP_JCB: begin
               dec.act = X_JC; dec.pops = 2'd2; dec.back = (op == OP_JCB);
            end
            default: dec.act = X_NOP;
         endcase
      end
   end

endmodule

// File: rtl/stack_core_alu.sv
module stack_core_alu
   import stack_core_pkg::*;
#(
   parameter int W          = 48,
   parameter bit CMP_SIGNED = 1'b1
) (
   input  logic [5:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);

   logic lt;
   logic eq;

   assign eq = (a == b);

   generate
      if (CMP_SIGNED) begin : g_signed
         assign lt = ($signed(a) < $signed(b));
      end else begin : g_unsigned
         assign lt = (a < b);
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:  res = a + b;
         OP_SUB:  res = a - b;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_EQV:  res = ~(a ^ b);
         OP_NOT:  res = ~b;
         OP_EQ:   res = W'(eq);
         OP_NE:   res = W'(!eq);
         OP_LT:   res = W'(lt);
         OP_LE:   res = W'(lt || eq);
         OP_GT:   res = W'(!lt && !eq);
         OP_GE:   res = W'(!lt);
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/stack_core_stk.sv
module stack_core_stk #(
   parameter  int W     = 48,
   parameter  int DEPTH = 32,
   localparam int PW    = $clog2(DEPTH),
   localparam int SPW   = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_a,
   input  logic [PW-1:0]  ix_a,
   input  logic [W-1:0]   d_a,
   input  logic           we_b,
   input  logic [PW-1:0]  ix_b,
   input  logic [W-1:0]   d_b,
   input  logic           sp_we,
   input  logic [SPW-1:0] sp_d,
   output logic [SPW-1:0] sp,
   output logic [W-1:0]   top,
   output logic [W-1:0]   sec
);

   logic [W-1:0]   cells [DEPTH];
   logic [SPW-1:0] sp_q;

   always_ff @(posedge clk) begin
      if (we_a) cells[ix_a] <= d_a;
      if (we_b) cells[ix_b] <= d_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     sp_q <= '0;
      else if (sp_we) sp_q <= sp_d;
   end

   assign sp  = sp_q;
   assign top = cells[PW'(sp_q - SPW'(1))];
   assign sec = cells[PW'(sp_q - SPW'(2))];

   // R11: occupancy never passes the configured depth
   p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SPW'(DEPTH));

   // R11: one syllable grows the stack by at most one entry
   p_grow_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q > $past(sp_q)) |-> (sp_q == $past(sp_q) + SPW'(1)));

endmodule

// File: rtl/stack_core.sv
module stack_core
   import stack_core_pkg::*;
#(
   parameter int          W          = 48,
   parameter int          SYL_W      = 12,
   parameter int          DEPTH      = 32,
   parameter int          AW         = 15,
   parameter int          IDX_W      = 10,
   parameter int          OFF_W      = 10,
   parameter logic [14:0] RESET_PC   = 15'd0,
   parameter bit          CMP_SIGNED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          ifetch_req,
   output logic [AW-1:0] ifetch_addr,
   input  logic          ifetch_valid,
   input  logic [W-1:0]  ifetch_word,
   output logic [IDX_W-1:0] ref_idx,
   input  logic [W-1:0]  ref_data,
   output logic          dmem_we,
   output logic [AW-1:0] dmem_addr,
   output logic [W-1:0]  dmem_wdata,
   input  logic [W-1:0]  dmem_rdata,
   output logic          stk_err
);

   localparam int SLOTS = W / SYL_W;
   localparam int SLW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int PW    = $clog2(DEPTH);
   localparam int SPW   = $clog2(DEPTH + 1);

   generate
      if (W % SYL_W != 0) begin : g_bad_pack
         $error("word width must hold a whole number of syllables");
      end
      if (SYL_W != IDX_W + 2) begin : g_bad_syl
         $error("syllable must be a 2-bit kind plus the index field");
      end
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("stack depth must be a power of two");
      end
      if (OFF_W > AW || AW > W || IDX_W < 6) begin : g_bad_width
         $error("offset, address and index widths are inconsistent");
      end
   endgenerate

   typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} seq_e;

   seq_e             state;
   logic [AW-1:0]    pc;
   logic [W-1:0]     word_q;
   logic [SLW-1:0]   slot;
   logic             err_q;

   logic [SYL_W-1:0] lanes [SLOTS];
   logic [SYL_W-1:0] syl;

   for (genvar g = 0; g < SLOTS; g++) begin : g_lane
      assign lanes[g] = word_q[W-1-g*SYL_W -: SYL_W];
   end
   assign syl = lanes[slot];

   dec_s             dec;
   logic [W-1:0]     alu_res;
   logic [W-1:0]     top, sec;
   logic [SPW-1:0]   sp;

   stack_core_dec u_dec (
      .kind (syl[SYL_W-1 -: 2]),
      .op   (syl[5:0]),
      .dec  (dec)
   );

   stack_core_alu #(.W(W), .CMP_SIGNED(CMP_SIGNED)) u_alu (
      .op  (syl[5:0]),
      .a   (sec),
      .b   (top),
      .res (alu_res)
   );

   logic           we_a, we_b, sp_we;
   logic [PW-1:0]  ix_a, ix_b;
   logic [W-1:0]   d_a, d_b;
   logic [SPW:0]   spx, need;
   logic           under, over, fault, go, take;
   logic [W-1:0]   push_val;
   logic [AW-1:0]  target;

   stack_core_stk #(.W(W), .DEPTH(DEPTH)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .we_a  (we_a),
      .ix_a  (ix_a),
      .d_a   (d_a),
      .we_b  (we_b),
      .ix_b  (ix_b),
      .d_b   (d_b),
      .sp_we (sp_we),
      .sp_d  (need[SPW-1:0]),
      .sp    (sp),
      .top   (top),
      .sec   (sec)
   );

   always_comb begin
      unique case (syl_kind_e'(syl[SYL_W-1 -: 2]))
         SYL_REF:  push_val = ref_data;
         SYL_ADDR: push_val = W'(ref_data[AW-1:0]);
         default:  push_val = W'(syl[IDX_W-1:0]);
      endcase
   end

   assign spx   = {1'b0, sp};
   assign need  = spx - (SPW+1)'(dec.pops) + (SPW+1)'(dec.pushes);
   assign under = spx < (SPW+1)'(dec.pops);
   assign over  = !under && (need > (SPW+1)'(DEPTH));
   assign fault = (state == ST_EXEC) && (under || over);
   assign go    = (state == ST_EXEC) && !fault;
   assign take  = go && ((dec.act == X_JMP) || (dec.act == X_JC && sec != '0));
   assign target = dec.back ? pc - AW'(top[OFF_W-1:0]) : pc + AW'(top[OFF_W-1:0]);

   always_comb begin
      we_a  = 1'b0;
      we_b  = 1'b0;
      ix_a  = PW'(sp - SPW'(1));
      ix_b  = PW'(sp - SPW'(2));
      d_a   = alu_res;
      d_b   = top;
      sp_we = go;
      if (go) begin
         unique case (dec.act)
            X_PUSH: begin we_a = 1'b1; ix_a = PW'(sp); d_a = push_val; end
            X_BIN:  begin we_a = 1'b1; ix_a = PW'(sp - SPW'(2)); end
            X_UN:   we_a = 1'b1;
            X_XCH:  begin we_a = 1'b1; d_a = sec; we_b = 1'b1; end
            X_DUP:  begin we_a = 1'b1; ix_a = PW'(sp); d_a = top; end
            X_LD:   begin we_a = 1'b1; d_a = dmem_rdata; end
            default: ;
         endcase
      end
   end

   assign dmem_addr  = top[AW-1:0];
   assign dmem_wdata = sec;
   assign dmem_we    = go && (dec.act == X_ST || dec.act == X_STK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_FETCH;
         pc     <= AW'(RESET_PC);
         word_q <= '0;
         slot   <= '0;
         err_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_FETCH: if (ifetch_valid) begin
               word_q <= ifetch_word;
               slot   <= '0;
               state  <= ST_EXEC;
            end
            ST_EXEC: begin
               if (fault) begin
                  err_q <= 1'b1;
                  state <= ST_HALT;
               end else if (take) begin
                  pc    <= target;
                  state <= ST_FETCH;
               end else if (slot == SLW'(SLOTS - 1)) begin
                  pc    <= pc + AW'(1);
                  state <= ST_FETCH;
               end else begin
                  slot  <= slot + SLW'(1);
               end
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   assign ifetch_req  = (state == ST_FETCH);
   assign ifetch_addr = pc;
   assign ref_idx     = syl[IDX_W-1:0];
   assign stk_err     = err_q;

   // R1: an accepted word is executed before another fetch is made
   p_fetch_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ifetch_req && ifetch_valid) |=> !ifetch_req);

   // R11: the error flag, once raised, stays raised
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stk_err |=> stk_err);

   // R11: a halted core neither fetches nor writes
   p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stk_err |-> (!ifetch_req && !dmem_we));

   // R1: the word address holds while a word's syllables execute
   p_pc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ifetch_req && !$past(ifetch_req) && !stk_err) |-> $stable(ifetch_addr));

endmodule

// File: tb/stack_core_test.sv
module stack_core_test;
   import stack_core_pkg::*;

   localparam logic [47:0] SENT = 48'h5A5A_0000_A5A5;
   localparam logic [47:0] NOPW = 48'h8008_0080_0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ifetch_req, ifetch_valid;
   logic [14:0] ifetch_addr;
   logic [47:0] ifetch_word;
   logic [9:0]  ref_idx;
   logic [47:0] ref_data;
   logic        dmem_we;
   logic [14:0] dmem_addr;
   logic [47:0] dmem_wdata, dmem_rdata;
   logic        stk_err;

   logic [47:0] prog [64];
   logic [47:0] dmem [512];
   int np = 0;
   int nfetch = 0;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   stack_core uut (
      .clk(clk), .rst_n(rst_n),
      .ifetch_req(ifetch_req), .ifetch_addr(ifetch_addr),
      .ifetch_valid(ifetch_valid), .ifetch_word(ifetch_word),
      .ref_idx(ref_idx), .ref_data(ref_data),
      .dmem_we(dmem_we), .dmem_addr(dmem_addr),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .stk_err(stk_err)
   );

   function automatic logic [47:0] ref_entry(input logic [9:0] i);
      return {16'hC3C3, 16'h0, 1'b0, i, 5'h15};
   endfunction

   assign ifetch_valid = ifetch_req;
   assign ifetch_word  = prog[ifetch_addr[5:0]];
   assign ref_data     = ref_entry(ref_idx);
   assign dmem_rdata   = dmem[dmem_addr[8:0]];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[8:0]] <= dmem_wdata;
      if (rst_n && ifetch_req && ifetch_valid) nfetch <= nfetch + 1;
   end

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put(input logic [1:0] k, input int f);
      logic [47:0] w;
      int s;
      w = prog[np / 4];
      s = np % 4;
      w[47 - 12*s -: 12] = {k, 10'(f)};
      prog[np / 4] = w;
      np++;
   endtask

   task automatic lit(input int v);  put(2'b00, v); endtask
   task automatic op(input logic [5:0] o); put(2'b10, int'(o)); endtask
   task automatic stv(input int a);  lit(a); op(OP_ST); endtask

   task automatic new_prog();
      for (int i = 0; i < 64; i++) prog[i] = NOPW;
      np = 0;
   endtask

   task automatic pad();
      while (np % 4 != 0) op(OP_NOP);
   endtask

   task automatic close_prog();
      pad(); lit(0); op(OP_JF); pad();
   endtask

   task automatic run(input int cyc);
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 512; i++) dmem[i] = SENT;
      nfetch = 0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R12 fetch request", 48'(ifetch_req), 48'd1);
      check("R12 fetch address", 48'(ifetch_addr), 48'd0);
      check("R12 no write", 48'(dmem_we), 48'd0);
      check("R12 error clear", 48'(stk_err), 48'd0);
   endtask

   task automatic t_arith();
      new_prog();
      lit(5); lit(3); op(OP_SUB); stv(100);
      lit(3); lit(5); op(OP_SUB); stv(101);
      lit(1023); lit(1); op(OP_ADD); stv(102);
      lit(4); lit(6); put(2'b10, 10'h3C0 | 10'(OP_ADD)); stv(103);
      close_prog();
      run(200);
      check("R4 sub 5-3", dmem[100], 48'd2);
      check("R4 sub 3-5", dmem[101], 48'hFFFF_FFFF_FFFE);
      check("R2 max literal add", dmem[102], 48'd1024);
      check("R4 upper op bits ignored", dmem[103], 48'd10);
   endtask

   task automatic t_logic();
      new_prog();
      lit(10'h3F0); lit(10'h0FF); op(OP_AND); stv(110);
      lit(10'h3F0); lit(10'h0FF); op(OP_OR);  stv(111);
      lit(10'h3F0); lit(10'h0FF); op(OP_EQV); stv(112);
      lit(0); op(OP_NOT); stv(113);
      close_prog();
      run(200);
      check("R5 and", dmem[110], 48'h0F0);
      check("R5 or", dmem[111], 48'h3FF);
      check("R5 equivalence", dmem[112], 48'hFFFF_FFFF_FCF0);
      check("R5 negate", dmem[113], 48'hFFFF_FFFF_FFFF);
   endtask

   task automatic t_cmp();
      new_prog();
      lit(3); lit(5); op(OP_LT); stv(120);
      lit(3); lit(5); op(OP_GE); stv(121);
      lit(5); lit(5); op(OP_EQ); stv(122);
      lit(5); lit(5); op(OP_NE); stv(123);
      lit(5); lit(5); op(OP_LE); stv(124);
      lit(0); lit(1); op(OP_SUB); lit(1); op(OP_GT); stv(125);
      lit(0); lit(1); op(OP_SUB); lit(1); op(OP_LT); stv(126);
      close_prog();
      run(300);
      check("R6 3<5", dmem[120], 48'd1);
      check("R6 3>=5", dmem[121], 48'd0);
      check("R6 5=5", dmem[122], 48'd1);
      check("R6 5!=5", dmem[123], 48'd0);
      check("R6 5<=5", dmem[124], 48'd1);
      check("R6 -1>1 signed", dmem[125], 48'd0);
      check("R6 -1<1 signed", dmem[126], 48'd1);
   endtask

   task automatic t_ref();
      new_prog();
      put(2'b01, 7);    stv(130);
      put(2'b11, 7);    stv(131);
      put(2'b01, 1023); stv(132);
      close_prog();
      run(200);
      check("R3 operand push", dmem[130], ref_entry(10'd7));
      check("R3 address push", dmem[131], 48'({10'd7, 5'h15}));
      check("R3 top index", dmem[132], ref_entry(10'd1023));
   endtask

   task automatic t_shuffle();
      new_prog();
      lit(1); lit(2); op(OP_XCH); stv(140); stv(141);
      lit(9); op(OP_DUP); op(OP_ADD); stv(142);
      lit(4); lit(7); op(OP_DEL); stv(143);
      close_prog();
      run(200);
      check("R7 exchange top", dmem[140], 48'd1);
      check("R7 exchange second", dmem[141], 48'd2);
      check("R7 duplicate", dmem[142], 48'd18);
      check("R7 delete", dmem[143], 48'd4);
   endtask

   task automatic t_mem();
      new_prog();
      lit(9); lit(200); op(OP_STK); stv(201);
      lit(200); op(OP_LD); stv(202);
      op(OP_DEL);
      run(200);
      check("R8 keep-store write", dmem[200], 48'd9);
      check("R8 kept value stored again", dmem[201], 48'd9);
      check("R8 load", dmem[202], 48'd9);
      check("R8 store pops both (empty after)", 48'(stk_err), 48'd1);
   endtask

   task automatic t_jump();
      new_prog();
      lit(3); op(OP_JF); pad();
      lit(7); lit(300); op(OP_ST); pad();
      lit(0); op(OP_JF); pad();
      lit(5); lit(301); op(OP_ST); pad();
      lit(3); op(OP_JB); pad();
      run(200);
      check("R9 forward jump target", dmem[301], 48'd5);
      check("R9 backward jump target", dmem[300], 48'd7);
      check("R9 no error", 48'(stk_err), 48'd0);
   endtask

   task automatic t_cjump();
      new_prog();
      lit(0); lit(2); op(OP_JCF); lit(1);
      lit(2); op(OP_JCF); pad();
      lit(9); lit(310); op(OP_ST); pad();
      lit(8); lit(311); op(OP_ST); op(OP_DEL);
      run(200);
      check("R10 false not taken, skipped word", dmem[310], SENT);
      check("R10 true taken", dmem[311], 48'd8);
      check("R10 offset and condition popped", 48'(stk_err), 48'd1);
   endtask

   task automatic t_under();
      new_prog();
      op(OP_ADD); lit(1); lit(340); op(OP_ST);
      close_prog();
      run(100);
      check("R11 underflow flag", 48'(stk_err), 48'd1);
      check("R11 halted after one fetch", 48'(nfetch), 48'd1);
      check("R11 no fetch request", 48'(ifetch_req), 48'd0);
      check("R11 no write after error", dmem[340], SENT);
   endtask

   task automatic t_full();
      new_prog();
      for (int i = 0; i < 32; i++) lit(i);
      op(OP_DEL); op(OP_DEL); lit(6); lit(330); op(OP_ST);
      close_prog();
      run(200);
      check("R11 32 entries legal", 48'(stk_err), 48'd0);
      check("R11 full stack store", dmem[330], 48'd6);
   endtask

   task automatic t_over();
      new_prog();
      for (int i = 0; i < 33; i++) lit(i);
      lit(1); lit(331); op(OP_ST);
      run(200);
      check("R11 overflow flag", 48'(stk_err), 48'd1);
      check("R11 no store after overflow", dmem[331], SENT);
      check("R1 nine words fetched", 48'(nfetch), 48'd9);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) prog[i] = NOPW;
      t_reset();
      t_arith();
      t_logic();
      t_cmp();
      t_ref();
      t_shuffle();
      t_mem();
      t_jump();
      t_cjump();
      t_under();
      t_full();
      t_over();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule